// File: doc/BRIEF.md
# Accumulator Processor Sequencer

A small stored-program processor core in which instructions and data share one synchronous memory. Each instruction is handled by a fixed sequence of register-transfer states. The program counter feeds a memory address register, and that register drives the memory address. The returned word is staged in a memory data register and then copied into an instruction register. The instruction register is then split into an opcode and an operand. The execute states either work on the accumulator directly or make a second memory access through the same address and data staging registers.

The core connects to one memory port that has one cycle of read latency. The port has an address output, a write-data output driven from the data staging register, a read-data input, and separate read and write strobes. An ALU handles these operations on the 16-bit accumulator: addition, subtraction, AND, OR, XOR, inversion and logical shifts. A zero flag follows every accumulator write. A conditional jump tests that flag. A halt instruction parks the core until the next reset.

Top module: `acc_fde_core`

## Requirements
- R1: While rstN is low, the program counter, accumulator, zero flag, address register and data register are cleared, memRd, memWr and halted are low, and memAddr is 0. After reset the first read is from address 0, and a STORE executed first writes 0.
- R2: Every instruction begins by copying the program counter into the address register. In the next cycle memRd is high with memAddr equal to that value, and the program counter advances by one. Instructions are fetched from consecutive addresses unless a jump intervenes.
- R3: An instruction word carries its opcode in bits [15:12] and its operand in bits [11:0]. The opcodes are 0 NOP, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 AND, 6 OR, 7 XOR, 8 NOT, 9 SHL, A SHR, B LDI, C JMP, D JZ, E NOP and F HALT.
- R4: LOAD copies the memory word at the operand address into the accumulator. LDI puts the operand, zero-extended, into the accumulator.
- R5: STORE moves the accumulator through the data register to the operand address. memWr is high for exactly one cycle, with memWdata equal to the accumulator.
- R6: ADD and SUB combine the accumulator with the memory word at the operand address, modulo 2^16.
- R7: AND, OR and XOR combine the accumulator bitwise with the memory word at the operand address. NOT inverts the accumulator.
- R8: SHL and SHR shift the accumulator left or right by operand[3:0] bit positions and fill with zeros. Operand bits above bit 3 are ignored.
- R9: The zero flag is set when a value written to the accumulator is 0 and cleared otherwise. STORE, JMP, JZ and NOP leave the flag unchanged.
- R10: JMP loads the program counter with the operand, so the next fetch is from that address.
- R11: JZ jumps to the operand when the zero flag is set. Otherwise execution falls through to the next address.
- R12: HALT raises halted. From then until reset, halted stays high and no read or write strobe is issued.
- R13: NOP, LDI, NOT, shifts, jumps and HALT take 5 cycles each. LOAD, STORE and the memory-operand ALU instructions take 7 cycles each. memRd and memWr are never high together, and neither strobe is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| memAddr | output | 12 | Memory address, driven from the address register |
| memWdata | output | 16 | Write data, driven from the data register |
| memRdata | input | 16 | Read data, valid the cycle after memRd |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| halted | output | 1 | High once a HALT instruction has executed |

## Verification
The first read strobe appears one rising edge after reset is released, and a HALT placed at address 0 raises halted on the fifth edge. The bench checks both outputs at the falling edge after the expected rising edge, and it also checks that halted is still low one cycle earlier. For every program the bench counts rising edges from reset release to halted and compares the count with the sum of 5 or 7 cycles per executed instruction. The count therefore shows whether the path through a jump is the correct one. Results computed by the ALU are read back from the memory model after the halt. Each value lands there through a STORE write strobe, which the bench also counts.

// File: rtl/acc_fde_pkg.sv
package acc_fde_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LOAD = 4'h1,
    OP_STORE= 4'h2,
    OP_ADD  = 4'h3,
    OP_SUB  = 4'h4,
    OP_AND  = 4'h5,
    OP_OR   = 4'h6,
    OP_XOR  = 4'h7,
    OP_NOT  = 4'h8,
    OP_SHL  = 4'h9,
    OP_SHR  = 4'hA,
    OP_LDI  = 4'hB,
    OP_JMP  = 4'hC,
    OP_JZ   = 4'hD,
    OP_RSV  = 4'hE,
    OP_HALT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR = 3'd0,
    ST_FETCH_MEM  = 3'd1,
    ST_FETCH_IR   = 3'd2,
    ST_DECODE     = 3'd3,
    ST_EXEC_ADDR  = 3'd4,
    ST_EXEC_MEM   = 3'd5,
    ST_EXEC_WB    = 3'd6,
    ST_HALTED     = 3'd7
  } seq_state_e;

  // register-transfer strobes from sequencer to datapath
  typedef struct packed {
    logic marFromPc;
    logic marFromOpnd;
    logic pcInc;
    logic pcLoad;
    logic mdrFromMem;
    logic mdrFromAcc;
    logic cirFromMdr;
    logic accWrite;
    logic aluSrcMem;
    logic memRd;
    logic memWr;
  } ctl_t;

endpackage

// File: rtl/acc_fde_alu.sv
module acc_fde_alu
  import acc_fde_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] result
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] shamt;
  assign shamt = bIn[SHAMT_W-1:0];

  always_comb begin
    unique case (opcode_e'(op))
      OP_LOAD, OP_LDI: result = bIn;
      OP_ADD:          result = accIn + bIn;
      OP_SUB:          result = accIn - bIn;
      OP_AND:          result = accIn & bIn;
      OP_OR:           result = accIn | bIn;
      OP_XOR:          result = accIn ^ bIn;
      OP_NOT:          result = ~accIn;
      OP_SHL:          result = accIn << shamt;
      OP_SHR:          result = accIn >> shamt;
      default:         result = accIn;
    endcase
  end

endmodule

// File: rtl/acc_fde_dpath.sv
module acc_fde_dpath
  import acc_fde_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [DATA_W-OP_W-1:0]   memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [OP_W-1:0]          opcode,
  output logic                     zeroFlag,
  output logic [DATA_W-OP_W-1:0]   pcNow
);

  localparam int ADDR_W = DATA_W - OP_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] cir;
  logic [DATA_W-1:0] acc;
  logic              zero;

  logic [ADDR_W-1:0] operand;
  logic [DATA_W-1:0] aluB;
  logic [DATA_W-1:0] aluOut;

  assign operand = cir[ADDR_W-1:0];
  assign opcode  = cir[DATA_W-1 -: OP_W];
  assign aluB    = ctl.aluSrcMem ? memRdata : DATA_W'(operand);

  acc_fde_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (opcode),
    .accIn (acc),
    .bIn   (aluB),
    .result(aluOut)
  );

  // program counter
  always_ff @(posedge clk) begin
    if (!rstN)            pc <= '0;
    else if (ctl.pcLoad)  pc <= operand;
    else if (ctl.pcInc)   pc <= pc + ADDR_W'(1);
  end

  // memory address register
  always_ff @(posedge clk) begin
    if (!rstN)                 mar <= '0;
    else if (ctl.marFromPc)    mar <= pc;
    else if (ctl.marFromOpnd)  mar <= operand;
  end

  // memory data register
  always_ff @(posedge clk) begin
    if (!rstN)                mdr <= '0;
    else if (ctl.mdrFromMem)  mdr <= memRdata;
    else if (ctl.mdrFromAcc)  mdr <= acc;
  end

  // current instruction register
  always_ff @(posedge clk) begin
    if (!rstN)                cir <= '0;
    else if (ctl.cirFromMdr)  cir <= mdr;
  end

  // accumulator and zero flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      zero <= 1'b0;
    end else if (ctl.accWrite) begin
      acc  <= aluOut;
      zero <= (aluOut == '0);
    end
  end

  assign memAddr  = mar;
  assign memWdata = mdr;
  assign zeroFlag = zero;
  assign pcNow    = pc;

endmodule

// File: rtl/acc_fde_ctrl.sv
module acc_fde_ctrl
  import acc_fde_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            zeroFlag,
  output ctl_t            ctl,
  output seq_state_e      stateNow,
  output logic            halted
);

  seq_state_e state, stateNext;
  opcode_e    op;

  assign op = opcode_e'(opcode);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH_ADDR;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_FETCH_ADDR: begin
        ctl.marFromPc = 1'b1;
        stateNext     = ST_FETCH_MEM;
      end
      ST_FETCH_MEM: begin
        ctl.memRd = 1'b1;
        ctl.pcInc = 1'b1;
        stateNext = ST_FETCH_IR;
      end
      ST_FETCH_IR: begin
        ctl.mdrFromMem = 1'b1;
        stateNext      = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.cirFromMdr = 1'b1;
        stateNext      = ST_EXEC_ADDR;
      end
      ST_EXEC_ADDR: begin
        stateNext = ST_FETCH_ADDR;
        unique case (op)
          OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
            ctl.marFromOpnd = 1'b1;
            stateNext       = ST_EXEC_MEM;
          end
          OP_NOT, OP_SHL, OP_SHR, OP_LDI: ctl.accWrite = 1'b1;
          OP_JMP:  ctl.pcLoad = 1'b1;
          OP_JZ:   ctl.pcLoad = zeroFlag;
          OP_HALT: stateNext  = ST_HALTED;
          default: ;
        endcase
      end
      ST_EXEC_MEM: begin
        stateNext = ST_EXEC_WB;
        if (op == OP_STORE) ctl.mdrFromAcc = 1'b1;
        else                ctl.memRd      = 1'b1;
      end
      ST_EXEC_WB: begin
        stateNext = ST_FETCH_ADDR;
        if (op == OP_STORE) begin
          ctl.memWr = 1'b1;
        end else begin
          ctl.mdrFromMem = 1'b1;
          ctl.accWrite   = 1'b1;
          ctl.aluSrcMem  = 1'b1;
        end
      end
      ST_HALTED: stateNext = ST_HALTED;
      default:   stateNext = ST_FETCH_ADDR;
    endcase
  end

  assign stateNow = state;
  assign halted   = (state == ST_HALTED);

endmodule

// File: rtl/acc_fde_core.sv
module acc_fde_core
  import acc_fde_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRd,
  output logic              memWr,
  output logic              halted
);

  ctl_t              ctl;
  seq_state_e        seqState;
  logic [OP_W-1:0]   opcode;
  logic              zeroFlag;
  logic [ADDR_W-1:0] pcNow;

  acc_fde_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .zeroFlag(zeroFlag),
    .ctl     (ctl),
    .stateNow(seqState),
    .halted  (halted)
  );

  acc_fde_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .opcode  (opcode),
    .zeroFlag(zeroFlag),
    .pcNow   (pcNow)
  );

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;

endmodule

// File: rtl/acc_fde_chk.sv
module acc_fde_chk
  import acc_fde_pkg::*;
#(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          memRd,
  input logic          memWr,
  input logic          halted,
  input seq_state_e    state,
  input logic [AW-1:0] pc
);

  a_r13_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  a_r13_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> !memWr);

  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  a_r12_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memRd && !memWr));

  // R2: the program counter has advanced by one when the fetched word arrives
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH_IR) |-> (pc == AW'($past(pc) + AW'(1))));

endmodule

bind acc_fde_core acc_fde_chk #(.AW(ADDR_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .memRd (memRd),
  .memWr (memWr),
  .halted(halted),
  .state (seqState),
  .pc    (pcNow)
);

// File: tb/acc_fde_core_bench.sv
module acc_fde_core_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        memRd;
  logic        memWr;
  logic        halted;

  logic [15:0] mem [256];
  int checks = 0;
  int failures = 0;
  int rdCount = 0;
  int wrCount = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  acc_fde_core u_acc_fde_core (
    .clk     (clk),
    .rstN    (rstN),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .memRd   (memRd),
    .memWr   (memWr),
    .halted  (halted)
  );

  // synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr[7:0]];
    if (memWr) mem[memAddr[7:0]] <= memWdata;
  end

  always @(negedge clk) begin
    if (memRd) rdCount = rdCount + 1;
    if (memWr) wrCount = wrCount + 1;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] opnd);
    return {op, opnd};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 8'h80; i < 8'h84; i++) mem[i] = 16'hDEAD;
  endtask

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // release reset at a falling edge and count rising edges until halted
  task automatic runProg(output int n);
    n = 0;
    rstN = 1'b1;
    while (!halted && n < 400) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic testResetAndHalt();
    int n;
    clearMem();
    mem[0] = ins(4'hF, 12'h000);
    holdReset();
    chk("R1 memRd in reset", 32'(memRd), 0);
    chk("R1 memWr in reset", 32'(memWr), 0);
    chk("R1 halted in reset", 32'(halted), 0);
    chk("R1 memAddr in reset", 32'(memAddr), 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 first read strobe", 32'(memRd), 1);
    chk("R2 first read address", 32'(memAddr), 0);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R13 halted not yet at edge 4", 32'(halted), 0);
    @(posedge clk); @(negedge clk);
    chk("R12 R13 halted at edge 5", 32'(halted), 1);
    rdCount = 0; wrCount = 0;
    repeat (20) @(negedge clk);
    chk("R12 no reads after halt", 32'(rdCount), 0);
    chk("R12 no writes after halt", 32'(wrCount), 0);
    chk("R12 halted sticky", 32'(halted), 1);
    n = 0;
  endtask

  task automatic testLogic();
    int n;
    clearMem();
    mem[8'h40] = 16'h0F00; mem[8'h41] = 16'h3C3C; mem[8'h42] = 16'hFFFF;
    mem[0] = ins(4'hB, 12'h0F0);
    mem[1] = ins(4'h6, 12'h040);
    mem[2] = ins(4'h5, 12'h041);
    mem[3] = ins(4'h7, 12'h042);
    mem[4] = ins(4'h2, 12'h080);
    mem[5] = ins(4'h8, 12'h000);
    mem[6] = ins(4'h2, 12'h081);
    mem[7] = ins(4'hF, 12'h000);
    holdReset();
    runProg(n);
    chk("R7 OR AND XOR result", 32'(mem[8'h80]), 32'h0000F3CF);
    chk("R7 NOT result", 32'(mem[8'h81]), 32'h00000C30);
    chk("R13 logic program cycles", 32'(n), 5+7+7+7+7+5+7+5);
  endtask

  task automatic testLoadStore();
    int n;
    clearMem();
    mem[8'h40] = 16'h1234;
    mem[0] = ins(4'h2, 12'h080);
    mem[1] = ins(4'h1, 12'h040);
    mem[2] = ins(4'h2, 12'h081);
    mem[3] = ins(4'hB, 12'hABC);
    mem[4] = ins(4'h2, 12'h082);
    mem[5] = ins(4'hF, 12'h000);
    holdReset();
    rdCount = 0; wrCount = 0;
    runProg(n);
    chk("R1 accumulator cleared by reset", 32'(mem[8'h80]), 0);
    chk("R4 LOAD", 32'(mem[8'h81]), 32'h1234);
    chk("R4 LDI zero-extended", 32'(mem[8'h82]), 32'h0ABC);
    chk("R5 one write strobe per STORE", 32'(wrCount), 3);
    chk("R2 reads: six fetches plus one load", 32'(rdCount), 7);
    chk("R13 load/store program cycles", 32'(n), 7+7+7+5+7+5);
  endtask

  task automatic testArith();
    int n;
    clearMem();
    mem[8'h40] = 16'hF001; mem[8'h41] = 16'h0001;
    mem[0] = ins(4'hB, 12'hFFF);
    mem[1] = ins(4'h3, 12'h040);
    mem[2] = ins(4'h2, 12'h080);
    mem[3] = ins(4'hD, 12'h005);
    mem[4] = ins(4'hF, 12'h000);
    mem[5] = ins(4'h4, 12'h041);
    mem[6] = ins(4'h2, 12'h081);
    mem[7] = ins(4'hF, 12'h000);
    holdReset();
    runProg(n);
    chk("R6 ADD wraps to zero", 32'(mem[8'h80]), 0);
    chk("R6 SUB wraps below zero", 32'(mem[8'h81]), 32'hFFFF);
    chk("R9 R11 JZ taken after zero sum past STORE", 32'(n), 5+7+7+5+7+7+5);
  endtask

  task automatic testShift();
    int n;
    clearMem();
    mem[0]  = ins(4'hB, 12'h001);
    mem[1]  = ins(4'h9, 12'h00F);
    mem[2]  = ins(4'h2, 12'h080);
    mem[3]  = ins(4'hA, 12'h013);
    mem[4]  = ins(4'h2, 12'h081);
    mem[5]  = ins(4'h9, 12'h000);
    mem[6]  = ins(4'h2, 12'h082);
    mem[7]  = ins(4'h9, 12'h004);
    mem[8]  = ins(4'hD, 12'h00A);
    mem[9]  = ins(4'hF, 12'h000);
    mem[10] = ins(4'hB, 12'h007);
    mem[11] = ins(4'h2, 12'h083);
    mem[12] = ins(4'hF, 12'h000);
    holdReset();
    runProg(n);
    chk("R8 SHL by 15", 32'(mem[8'h80]), 32'h8000);
    chk("R8 SHR uses operand[3:0] only", 32'(mem[8'h81]), 32'h1000);
    chk("R8 shift by zero", 32'(mem[8'h82]), 32'h1000);
    chk("R9 shift out to zero sets flag", 32'(mem[8'h83]), 32'h0007);
  endtask

  task automatic testJumps();
    int n;
    clearMem();
    mem[0]  = ins(4'hB, 12'h001);
    mem[1]  = ins(4'hD, 12'h005);
    mem[2]  = ins(4'h2, 12'h080);
    mem[3]  = ins(4'hC, 12'h006);
    mem[4]  = ins(4'hF, 12'h000);
    mem[5]  = ins(4'hF, 12'h000);
    mem[6]  = ins(4'hB, 12'h000);
    mem[7]  = ins(4'h2, 12'h081);
    mem[8]  = ins(4'h0, 12'h000);
    mem[9]  = ins(4'hD, 12'h00B);
    mem[10] = ins(4'hF, 12'h000);
    mem[11] = ins(4'hB, 12'h055);
    mem[12] = ins(4'h2, 12'h082);
    mem[13] = ins(4'hF, 12'h000);
    holdReset();
    runProg(n);
    chk("R11 JZ not taken falls through", 32'(mem[8'h80]), 1);
    chk("R10 JMP reaches target", 32'(mem[8'h81]), 0);
    chk("R9 R11 flag survives STORE and NOP", 32'(mem[8'h82]), 32'h0055);
    chk("R3 R13 jump program cycles", 32'(n), 5+5+7+5+5+7+5+5+5+7+5);
  endtask

  initial begin
    testResetAndHalt();
    testLogic();
    testLoadStore();
    testArith();
    testShift();
    testJumps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule